// File: doc/BRIEF.md
# Audio Mixer Control Register Bank

This block holds the control state of an audio mixer behind a small synchronous host port. The host gives an even 7-bit address and 16-bit data. The port takes a write on any clock edge where `wr_en` is high. Read data is combinational from the current address. Two registers are implemented.

The identification register sits at 00h. A read of it returns a fixed capability word. A write to it, whatever the data, puts every register back to its default value.

The master volume register sits at 02h. It holds a mute flag and one 5-bit attenuation code for each of the left and right channels, in 1.5 dB steps: code 0 is 0 dB and code 1Fh is 46.5 dB. Each channel field has an optional sixth bit. When that bit is written as 1, the channel saturates to the largest attenuation. The bank also drives the mute flag and the two attenuation codes as registered outputs, so the analog path can use them directly.

The host port is a plain register access port. There is no valid/ready stream and no back-pressure: every write is accepted on the edge where it is presented.

Top module: `mix_ctl_bank`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, a read of 02h returns 8000h, `mute_o` is 1, and both attenuation outputs are 0.
- R2: A read of 00h always returns 6A90h, including after writes to 00h.
- R3: A write to 02h stores bit 15 as mute, bits 12:8 as the left code and bits 4:0 as the right code. A read of 02h returns them in the same positions.
- R4: A write to 02h with bit 13 set stores 1Fh as the left code, whatever bits 12:8 hold. With bit 5 set, it stores 1Fh as the right code, whatever bits 4:0 hold.
- R5: Bits 14:13 and 7:5 of register 02h always read as 0, whatever was written to them.
- R6: A write to 00h with any data makes register 02h read 8000h from the following cycle. It sets the outputs to mute=1 with both codes 0.
- R7: A read of any address other than 00h and 02h, odd addresses included, returns 0000h. A write to such an address changes neither register nor any output.
- R8: `mute_o`, `left_att_o` and `right_att_o` equal the mute, left and right fields of register 02h. They change in the cycle after the write edge.
- R9: While `wr_en` is low, register 02h and the outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 7 | Register byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| mute_o | output | 1 | Mute flag, 1 = muted |
| left_att_o | output | 5 | Left attenuation code, 1.5 dB per step |
| right_att_o | output | 5 | Right attenuation code, 1.5 dB per step |

## Verification
Register state and the decoded outputs change on the rising edge where the write is presented. They are therefore due one cycle after the write, and read data follows the address with no delay. The bench drives address and data on the falling edge and lets one rising edge pass. It then compares `rdata` and the three outputs on the next falling edge with a model updated at that same write. Reads are checked on the falling edge where their address is applied. A reset write is followed at once by a read of 02h, which shows that its effect lands in the very next cycle.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 16;
  localparam int ATT_W   = 5;
  localparam int NUM_CH  = 2;
  localparam logic [ADDR_W-1:0] ADDR_ID  = 7'h00;
  localparam logic [ADDR_W-1:0] ADDR_VOL = 7'h02;
  localparam logic [DATA_W-1:0] ID_WORD  = 16'h6A90;
  localparam int MUTE_BIT = 15;
  localparam logic [ATT_W-1:0] ATT_MAX = '1;

  // channel 0 is left, channel 1 is right; low bit of each field
  function automatic int ch_lsb(input int ch);
    return (ch == 0) ? 8 : 0;
  endfunction

  // six-bit field to stored code: sixth bit forces full attenuation
  function automatic logic [ATT_W-1:0] sat_code(input logic [ATT_W:0] f);
    return f[ATT_W] ? ATT_MAX : f[ATT_W-1:0];
  endfunction
endpackage

// File: rtl/mix_addr_dec.sv
module mix_addr_dec
  import mix_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_id,
  output logic              hit_vol,
  output logic              wr_rst,
  output logic              wr_vol
);
  always_comb begin
    hit_id  = (addr == ADDR_ID);
    hit_vol = (addr == ADDR_VOL);
    wr_rst  = wr_en && hit_id;
    wr_vol  = wr_en && hit_vol;
  end

  always_comb begin
    assert (!(hit_id && hit_vol)) else $error("p_dec_excl_r7");
  end
endmodule

// File: rtl/mix_vol_reg.sv
module mix_vol_reg
  import mix_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vol,
  input  logic              wr_rst,
  input  logic [DATA_W-1:0] wdata,
  output logic              mute,
  output logic [ATT_W-1:0]  att [NUM_CH]
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mute <= 1'b1;
    else if (wr_rst) mute <= 1'b1;
    else if (wr_vol) mute <= wdata[MUTE_BIT];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int LSB = ch_lsb(c);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      att[c] <= '0;
      else if (wr_rst) att[c] <= '0;
      else if (wr_vol) att[c] <= sat_code(wdata[LSB+ATT_W:LSB]);
    end

    p_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vol && !wr_rst && wdata[LSB+ATT_W]) |=> (att[c] == ATT_MAX));
    p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rst |=> (att[c] == '0));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_vol && !wr_rst) |=> $stable(att[c]));
  end

  p_mute_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> mute);
  p_mute_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_vol && !wr_rst) |=> $stable(mute));
endmodule

// File: rtl/mix_ctl_bank.sv
module mix_ctl_bank
  import mix_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [6:0]        addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              mute_o,
  output logic [4:0]        left_att_o,
  output logic [4:0]        right_att_o
);
  logic hit_id, hit_vol, wr_rst, wr_vol;
  logic mute;
  logic [ATT_W-1:0] att [NUM_CH];
  logic [DATA_W-1:0] vol_word;

  mix_addr_dec u_dec (
    .wr_en(wr_en), .addr(addr),
    .hit_id(hit_id), .hit_vol(hit_vol),
    .wr_rst(wr_rst), .wr_vol(wr_vol)
  );

  mix_vol_reg u_vol (
    .clk(clk), .rst_n(rst_n),
    .wr_vol(wr_vol), .wr_rst(wr_rst), .wdata(wdata),
    .mute(mute), .att(att)
  );

  always_comb begin
    vol_word = '0;
    vol_word[MUTE_BIT] = mute;
    for (int c = 0; c < NUM_CH; c++)
      vol_word[ch_lsb(c) +: ATT_W] = att[c];
  end

  always_comb begin
    if (hit_id)       rdata = ID_WORD;
    else if (hit_vol) rdata = vol_word;
    else              rdata = '0;
  end

  assign mute_o      = mute;
  assign left_att_o  = att[0];
  assign right_att_o = att[1];

  p_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_ID) |-> (rdata == ID_WORD));
  p_resv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_VOL) |-> (rdata[14:13] == 2'b00 && rdata[7:5] == 3'b000));
  p_unimp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != ADDR_ID && addr != ADDR_VOL) |-> (rdata == '0));
  p_out_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_VOL) |=> (mute_o == $past(wdata[15])));
endmodule

// File: tb/mix_ctl_bank_test.sv
module mix_ctl_bank_test;
  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0;
  logic [6:0] addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic mute_o;
  logic [4:0] left_att_o, right_att_o;
  int total = 0, bad = 0;
  logic [15:0] model = 16'h8000;

  always #2 clk = ~clk;

  mix_ctl_bank uut (.*);

  function automatic logic [4:0] sat(input logic [5:0] f);
    return f[5] ? 5'h1F : f[4:0];
  endfunction

  function automatic logic [15:0] stored(input logic [15:0] d);
    return {d[15], 2'b00, sat(d[13:8]), 3'b000, sat(d[5:0])};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    if (a == 7'h00) model = 16'h8000;
    else if (a == 7'h02) model = stored(d);
  endtask

  task automatic rd(input logic [6:0] a, input logic [15:0] exp, input string tag);
    addr = a;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic chk_all(input string tag);
    rd(7'h02, model, tag);
    chk({tag, " R8 mute"}, {15'd0, mute_o}, {15'd0, model[15]});
    chk({tag, " R8 left"}, {11'd0, left_att_o}, {11'd0, model[12:8]});
    chk({tag, " R8 right"}, {11'd0, right_att_o}, {11'd0, model[4:0]});
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_all("R1 reset");
    rd(7'h00, 16'h6A90, "R2 id");
    wr(7'h02, 16'h1F1F);
    chk_all("R3 plain");
    wr(7'h02, 16'h8A05);
    chk_all("R3 mute+codes");
    wr(7'h02, 16'h2000);
    chk_all("R4 left sixth bit");
    wr(7'h02, 16'h0021);
    chk_all("R4 right sixth bit");
    wr(7'h02, 16'h7FFF);
    rd(7'h02, 16'h1F1F, "R5 reserved zero");
    wr(7'h00, 16'h1234);
    rd(7'h02, 16'h8000, "R6 reset write next cycle");
    chk_all("R6 outputs");
    rd(7'h00, 16'h6A90, "R2 id after reset write");
    wr(7'h02, 16'h0305);
    wr(7'h04, 16'hFFFF);
    chk_all("R7 write ignored");
    wr(7'h03, 16'h0000);
    chk_all("R7 odd write ignored");
    rd(7'h04, 16'h0000, "R7 read unimpl");
    rd(7'h01, 16'h0000, "R7 read odd");
    repeat (3) @(negedge clk);
    chk_all("R9 idle hold");
    for (int i = 0; i < 300; i++) begin
      logic [3:0] op;
      logic [15:0] d;
      op = 4'($urandom_range(0, 9));
      d  = 16'($urandom);
      if (op < 6)       wr(7'h02, d);
      else if (op == 6) wr(7'h00, d);
      else if (op == 7) wr(7'($urandom_range(4, 127)), d);
      else begin
        @(negedge clk);
        rd(7'h00, 16'h6A90, "R2 rand id");
      end
      chk_all("R3 R4 rand");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule